// File: doc/BRIEF.md
# Dual-Channel UART Host Bus Interface

This block is the host-facing register front end of a two-channel serial controller built on the classic 550-style register map. A host drives an 8-bit data bus, a 3-bit register offset, two active-low channel selects and active-low read and write strobes. The block brings the strobes and selects into the system clock domain, decides which channel an access belongs to, and either serves the access from the registers it holds itself or forwards it to that channel's register bank.

Per channel it holds the line control register and the two divisor latch bytes. Bit 7 of the line control register is the divisor-latch access bit. When it is set, offsets 0 and 1 reach the low and high divisor bytes. When both divisor bytes of a channel are zero, those two offsets read back a fixed revision code and a fixed identification code instead. Every other access is passed to the channel's own bank. The interrupt and ready lines of each channel pass straight through.

Top module: `duart_host_if`

## Requirements
- R1: After an active-high `rst`, the line control register and both divisor bytes of each channel read 0x00, and `data_oe` is low.
- R2: `data_oe` is high only while the synchronised read strobe is low and at least one synchronised channel select is low. In every other case it is low and `data_out` is 0x00.
- R3: A write takes effect only when the synchronised write strobe rises while a channel select is low. While the strobe is held low nothing changes. A write with both selects high has no effect.
- R4: `cs_a_n` low selects channel A (index 0) and `cs_b_n` low selects channel B (index 1). Writes to one channel leave the other channel unchanged.
- R5: Offset 3 is the line control register. It can be written and read back at any time, and its bit 7 is the divisor-latch access bit.
- R6: With bit 7 of the line control register set, offset 0 writes and reads the low divisor byte and offset 1 writes and reads the high divisor byte.
- R7: With bit 7 set and both divisor bytes of the channel equal to 0x00, a read of offset 1 returns 0x0A and a read of offset 0 returns 0x01. If either byte is nonzero, the stored bytes are returned.
- R8: Any access that is neither to offset 3 nor to offsets 0/1 with bit 7 set goes to the channel bank. A write produces a one-cycle `ch_wr_o[ch]` pulse with `ch_addr_o` = offset and `ch_wdata_o` = data. A read returns that channel's slice of `ch_rdata_i` (channel A in bits 7:0).
- R9: With both selects low, a write updates both channels, and a read returns channel A's data.
- R10: `irq_o`, `rxrdy_n_o` and `txrdy_n_o` equal `irq_i`, `rxrdy_n_i` and `txrdy_n_i` bit for bit.
- R11: Writes to the line control register or the divisor bytes produce no `ch_wr_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high reset |
| addr | input | 3 | Register offset |
| data_in | input | 8 | Host write data |
| data_out | output | 8 | Host read data |
| data_oe | output | 1 | Drive enable for the shared host bus |
| cs_a_n | input | 1 | Channel A select, active low |
| cs_b_n | input | 1 | Channel B select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low (commits on release) |
| ch_wr_o | output | 2 | Per-channel bank write pulse |
| ch_addr_o | output | 3 | Offset forwarded to the banks |
| ch_wdata_o | output | 8 | Write data forwarded to the banks |
| ch_rdata_i | input | 16 | Bank read data, channel A in bits 7:0 |
| irq_i | input | 2 | Channel interrupt requests |
| irq_o | output | 2 | Interrupt requests passed through |
| rxrdy_n_i | input | 2 | Channel receive-ready lines |
| rxrdy_n_o | output | 2 | Receive-ready passed through |
| txrdy_n_i | input | 2 | Channel transmit-ready lines |
| txrdy_n_o | output | 2 | Transmit-ready passed through |

## Verification
The divisor bytes are swept over several pairs: both zero, each one nonzero alone, both nonzero, and a value with only the top bit set. This separates the identification substitution from normal readback and catches a substitution that tests only one of the two bytes. Every offset other than 3 is read and written with the access bit clear, which shows that forwarding to the bank is complete and that no offset is caught by the local registers. Accesses with A only, B only, both selects and no select separate the channel routing, the dual-write case, the read priority for A, and the ignored accesses. A write held open for several cycles shows that the commit happens on the strobe release.

// File: rtl/duart_host_if_pkg.sv
package duart_host_if_pkg;
   localparam int unsigned DATA_W  = 8;
   localparam int unsigned OFF_W   = 3;
   localparam int unsigned NUM_CH  = 2;
   localparam logic [OFF_W-1:0] OFF_DIV_LO = 3'd0;
   localparam logic [OFF_W-1:0] OFF_DIV_HI = 3'd1;
   localparam logic [OFF_W-1:0] OFF_LINE   = 3'd3;
   localparam int unsigned ACCESS_BIT = 7;
endpackage

// File: rtl/duart_sync.sv
module duart_sync #(
   parameter int unsigned WIDTH   = 4,
   parameter int unsigned STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("duart_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
      end else begin
         stage_q[0] <= d;
         for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/duart_chan_regs.sv
module duart_chan_regs
   import duart_host_if_pkg::*;
#(
   parameter logic [DATA_W-1:0] ID_CODE  = 8'h0A,
   parameter logic [DATA_W-1:0] REV_CODE = 8'h01
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [OFF_W-1:0]  off,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] bank_rdata,
   output logic [DATA_W-1:0] rdata,
   output logic              bank_wr,
   output logic [DATA_W-1:0] line_q,
   output logic              access_on,
   output logic              id_mode
);
   logic [DATA_W-1:0] div_lo_q, div_hi_q;
   logic hit_line, hit_lo, hit_hi;

   assign access_on = line_q[ACCESS_BIT];
   assign hit_line  = (off == OFF_LINE);
   assign hit_lo    = access_on && (off == OFF_DIV_LO);
   assign hit_hi    = access_on && (off == OFF_DIV_HI);
   assign id_mode   = (div_lo_q == '0) && (div_hi_q == '0);
   assign bank_wr   = wr_en && !(hit_line || hit_lo || hit_hi);

   always_ff @(posedge clk) begin
      if (rst) begin
         line_q   <= '0;
         div_lo_q <= '0;
         div_hi_q <= '0;
      end else if (wr_en) begin
         if (hit_line) line_q   <= wdata;
         if (hit_lo)   div_lo_q <= wdata;
         if (hit_hi)   div_hi_q <= wdata;
      end
   end

   always_comb begin
      if (hit_line)    rdata = line_q;
      else if (hit_lo) rdata = id_mode ? REV_CODE : div_lo_q;
      else if (hit_hi) rdata = id_mode ? ID_CODE  : div_hi_q;
      else             rdata = bank_rdata;
   end
endmodule

// File: rtl/duart_host_if.sv
module duart_host_if
   import duart_host_if_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [DATA_W-1:0] ID_CODE  = 8'h0A,
   parameter logic [DATA_W-1:0] REV_CODE = 8'h01
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [2:0]        addr,
   input  logic [7:0]        data_in,
   output logic [7:0]        data_out,
   output logic              data_oe,
   input  logic              cs_a_n,
   input  logic              cs_b_n,
   input  logic              rd_n,
   input  logic              wr_n,
   output logic [1:0]        ch_wr_o,
   output logic [2:0]        ch_addr_o,
   output logic [7:0]        ch_wdata_o,
   input  logic [15:0]       ch_rdata_i,
   input  logic [1:0]        irq_i,
   output logic [1:0]        irq_o,
   input  logic [1:0]        rxrdy_n_i,
   output logic [1:0]        rxrdy_n_o,
   input  logic [1:0]        txrdy_n_i,
   output logic [1:0]        txrdy_n_o
);
   localparam int unsigned CTRL_W = NUM_CH + 2;

   generate
      if (DATA_W != 8 || OFF_W != 3 || NUM_CH != 2) begin : g_bad_cfg
         $error("duart_host_if: port widths fixed at 8/3/2");
      end
   endgenerate

   logic [CTRL_W-1:0] ctrl_s;
   logic              rd_s, wr_s, wr_prev_q, wr_commit;
   logic [NUM_CH-1:0] sel_s;
   logic [DATA_W-1:0] chan_rdata [NUM_CH];
   logic [DATA_W-1:0] chan_line  [NUM_CH];
   logic [NUM_CH-1:0] chan_access, chan_idm;

   duart_sync #(.WIDTH(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   ({cs_b_n, cs_a_n, wr_n, rd_n}),
      .q   (ctrl_s)
   );

   assign rd_s  = ctrl_s[0];
   assign wr_s  = ctrl_s[1];
   assign sel_s = ~ctrl_s[CTRL_W-1:2];

   always_ff @(posedge clk) begin
      if (rst) wr_prev_q <= 1'b1;
      else     wr_prev_q <= wr_s;
   end

   assign wr_commit = wr_s && !wr_prev_q;

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
         duart_chan_regs #(.ID_CODE(ID_CODE), .REV_CODE(REV_CODE)) u_regs (
            .clk        (clk),
            .rst        (rst),
            .wr_en      (wr_commit && sel_s[ch]),
            .off        (addr),
            .wdata      (data_in),
            .bank_rdata (ch_rdata_i[ch*DATA_W +: DATA_W]),
            .rdata      (chan_rdata[ch]),
            .bank_wr    (ch_wr_o[ch]),
            .line_q     (chan_line[ch]),
            .access_on  (chan_access[ch]),
            .id_mode    (chan_idm[ch])
         );
      end
   endgenerate

   assign ch_addr_o  = addr;
   assign ch_wdata_o = data_in;

   assign data_oe = !rd_s && (|sel_s);

   always_comb begin
      if (!data_oe)      data_out = '0;
      else if (sel_s[0]) data_out = chan_rdata[0];
      else               data_out = chan_rdata[1];
   end

   assign irq_o     = irq_i;
   assign rxrdy_n_o = rxrdy_n_i;
   assign txrdy_n_o = txrdy_n_i;
endmodule

// File: rtl/duart_host_if_chk.sv
module duart_host_if_chk (
   input logic       clk,
   input logic       rst,
   input logic       wr_n,
   input logic       data_oe,
   input logic [7:0] data_out,
   input logic [2:0] addr,
   input logic [1:0] ch_wr_o,
   input logic [1:0] sel_s,
   input logic       wr_commit,
   input logic [7:0] line_a,
   input logic [7:0] line_b,
   input logic [1:0] chan_access,
   input logic [1:0] chan_idm
);
   // R2: bus enable always comes with a selected channel
   a_r2_oe_needs_select: assert property (@(posedge clk) disable iff (rst)
      data_oe |-> (sel_s != 2'b00));

   // R2: bus is quiet when not enabled
   a_r2_quiet_bus: assert property (@(posedge clk) disable iff (rst)
      !data_oe |-> (data_out == 8'h00));

   // R3, R8: bank pulses last one cycle and follow a released strobe
   a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
      (ch_wr_o != 2'b00) |=> (ch_wr_o == 2'b00));
   a_r3_after_release: assert property (@(posedge clk) disable iff (rst)
      (ch_wr_o != 2'b00) |-> $past(wr_n));

   // R3, R5: line control registers only move on a commit
   a_r3_line_hold: assert property (@(posedge clk) disable iff (rst)
      !wr_commit |=> ($stable(line_a) && $stable(line_b)));

   // R7: identification readback on channel A
   a_r7_id_code: assert property (@(posedge clk) disable iff (rst)
      (data_oe && sel_s[0] && chan_access[0] && chan_idm[0] && addr == 3'd1)
         |-> (data_out == 8'h0A));
   a_r7_rev_code: assert property (@(posedge clk) disable iff (rst)
      (data_oe && sel_s[0] && chan_access[0] && chan_idm[0] && addr == 3'd0)
         |-> (data_out == 8'h01));

   // R11: no bank pulse on local register offsets
   a_r11_local_no_bank: assert property (@(posedge clk) disable iff (rst)
      (addr == 3'd3) |-> (ch_wr_o == 2'b00));
endmodule

bind duart_host_if duart_host_if_chk u_chk (
   .clk         (clk),
   .rst         (rst),
   .wr_n        (wr_n),
   .data_oe     (data_oe),
   .data_out    (data_out),
   .addr        (addr),
   .ch_wr_o     (ch_wr_o),
   .sel_s       (sel_s),
   .wr_commit   (wr_commit),
   .line_a      (chan_line[0]),
   .line_b      (chan_line[1]),
   .chan_access (chan_access),
   .chan_idm    (chan_idm)
);

// File: tb/duart_host_if_tb.sv
module duart_host_if_tb;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [2:0] addr = '0;
   logic [7:0] data_in = '0;
   logic [7:0] data_out;
   logic data_oe;
   logic cs_a_n = 1'b1, cs_b_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [1:0] ch_wr_o;
   logic [2:0] ch_addr_o;
   logic [7:0] ch_wdata_o;
   logic [15:0] ch_rdata_i;
   logic [1:0] irq_i = 2'b00, irq_o, rxrdy_n_i = 2'b11, rxrdy_n_o, txrdy_n_i = 2'b11, txrdy_n_o;

   int checks = 0, fails = 0;
   int pulses_a = 0, pulses_b = 0;
   logic [2:0] last_addr;
   logic [7:0] last_data;
   logic done = 1'b0;

   always #5 clk = ~clk;

   assign ch_rdata_i = {8'hB0 ^ {5'd0, addr}, 8'hA0 ^ {5'd0, addr}};

   duart_host_if u_dut (
      .clk(clk), .rst(rst), .addr(addr), .data_in(data_in), .data_out(data_out),
      .data_oe(data_oe), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .rd_n(rd_n), .wr_n(wr_n),
      .ch_wr_o(ch_wr_o), .ch_addr_o(ch_addr_o), .ch_wdata_o(ch_wdata_o),
      .ch_rdata_i(ch_rdata_i), .irq_i(irq_i), .irq_o(irq_o),
      .rxrdy_n_i(rxrdy_n_i), .rxrdy_n_o(rxrdy_n_o),
      .txrdy_n_i(txrdy_n_i), .txrdy_n_o(txrdy_n_o));

   always @(posedge clk) begin
      if (!rst) begin
         if (ch_wr_o[0]) pulses_a <= pulses_a + 1;
         if (ch_wr_o[1]) pulses_b <= pulses_b + 1;
         if (|ch_wr_o) begin
            last_addr <= ch_addr_o;
            last_data <= ch_wdata_o;
         end
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic bus_wr(input logic ca, input logic cb, input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; data_in = d; cs_a_n = ca; cs_b_n = cb;
      wait_cyc(1);
      wr_n = 1'b0;
      wait_cyc(4);
      wr_n = 1'b1;
      wait_cyc(5);
      cs_a_n = 1'b1; cs_b_n = 1'b1;
      wait_cyc(3);
   endtask

   task automatic bus_rd(input logic ca, input logic cb, input logic [2:0] a,
                         output logic [7:0] d, output logic oe);
      @(negedge clk);
      addr = a; cs_a_n = ca; cs_b_n = cb;
      wait_cyc(1);
      rd_n = 1'b0;
      wait_cyc(4);
      d = data_out; oe = data_oe;
      rd_n = 1'b1;
      wait_cyc(1);
      cs_a_n = 1'b1; cs_b_n = 1'b1;
      wait_cyc(3);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] rv;
      logic oe;
      logic [7:0] lo_pat [6];
      logic [7:0] hi_pat [6];
      int pa, pb;
      lo_pat = '{8'h00, 8'h01, 8'h00, 8'h5A, 8'hFF, 8'h00};
      hi_pat = '{8'h00, 8'h00, 8'h01, 8'hC3, 8'hFF, 8'h80};

      wait_cyc(4);
      rst = 1'b0;
      wait_cyc(2);
      check("R1 oe after reset", {31'd0, data_oe}, 0);

      // R10 pass-through
      irq_i = 2'b01; rxrdy_n_i = 2'b10; txrdy_n_i = 2'b01;
      #1;
      check("R10 irq", {30'd0, irq_o}, 2'b01);
      check("R10 rxrdy", {30'd0, rxrdy_n_o}, 2'b10);
      check("R10 txrdy", {30'd0, txrdy_n_o}, 2'b01);
      irq_i = 2'b10;
      #1;
      check("R10 irq swap", {30'd0, irq_o}, 2'b10);

      // R1 reset values
      bus_rd(0, 1, 3'd3, rv, oe);
      check("R1 line A", rv, 8'h00);
      check("R2 oe on read", {31'd0, oe}, 1);
      bus_rd(1, 0, 3'd3, rv, oe);
      check("R1 line B", rv, 8'h00);

      // R2 read strobe without select
      @(negedge clk); rd_n = 1'b0; wait_cyc(4);
      check("R2 oe no select", {31'd0, data_oe}, 0);
      check("R2 bus quiet", data_out, 8'h00);
      rd_n = 1'b1; wait_cyc(3);

      // R7 straight after reset
      bus_wr(0, 1, 3'd3, 8'h80);
      bus_rd(0, 1, 3'd1, rv, oe);
      check("R7 id after reset", rv, 8'h0A);
      bus_rd(0, 1, 3'd0, rv, oe);
      check("R7 rev after reset", rv, 8'h01);

      // R6/R7/R11 divisor sweep on channel A
      pa = pulses_a; pb = pulses_b;
      for (int p = 0; p < 6; p++) begin
         logic idm;
         bus_wr(0, 1, 3'd0, lo_pat[p]);
         bus_wr(0, 1, 3'd1, hi_pat[p]);
         idm = (lo_pat[p] == 8'h00) && (hi_pat[p] == 8'h00);
         bus_rd(0, 1, 3'd0, rv, oe);
         check(idm ? "R7 rev sweep" : "R6 lo sweep", rv, idm ? 8'h01 : lo_pat[p]);
         bus_rd(0, 1, 3'd1, rv, oe);
         check(idm ? "R7 id sweep" : "R6 hi sweep", rv, idm ? 8'h0A : hi_pat[p]);
      end
      check("R11 no bank pulse A", pulses_a - pa, 0);
      check("R11 no bank pulse B", pulses_b - pb, 0);

      // R8 bank forwarding, access bit clear
      bus_wr(0, 1, 3'd3, 8'h03);
      bus_rd(0, 1, 3'd3, rv, oe);
      check("R5 line readback", rv, 8'h03);
      for (int a = 0; a < 8; a++) begin
         if (a != 3) begin
            bus_rd(0, 1, 3'(a), rv, oe);
            check("R8 bank read A", rv, 8'hA0 ^ 8'(a));
            pa = pulses_a; pb = pulses_b;
            bus_wr(0, 1, 3'(a), 8'h10 + 8'(a));
            check("R8 pulse A", pulses_a - pa, 1);
            check("R4 no pulse B", pulses_b - pb, 0);
            check("R8 fwd addr", {29'd0, last_addr}, a);
            check("R8 fwd data", last_data, 8'h10 + 8'(a));
         end
      end

      // R4 channel B independent
      bus_wr(1, 0, 3'd3, 8'h80);
      bus_wr(1, 0, 3'd0, 8'h22);
      bus_wr(1, 0, 3'd1, 8'h00);
      bus_rd(1, 0, 3'd0, rv, oe);
      check("R4 B lo", rv, 8'h22);
      bus_rd(1, 0, 3'd1, rv, oe);
      check("R4 B hi", rv, 8'h00);
      bus_rd(0, 1, 3'd3, rv, oe);
      check("R4 A line kept", rv, 8'h03);
      bus_wr(1, 0, 3'd3, 8'h00);
      bus_rd(1, 0, 3'd2, rv, oe);
      check("R8 bank read B", rv, 8'hB2);

      // R9 both selects
      pa = pulses_a; pb = pulses_b;
      bus_wr(0, 0, 3'd5, 8'h77);
      check("R9 dual pulse A", pulses_a - pa, 1);
      check("R9 dual pulse B", pulses_b - pb, 1);
      bus_wr(0, 0, 3'd3, 8'h9F);
      bus_rd(0, 1, 3'd3, rv, oe);
      check("R9 line A", rv, 8'h9F);
      bus_rd(1, 0, 3'd3, rv, oe);
      check("R9 line B", rv, 8'h9F);
      bus_wr(0, 1, 3'd0, 8'h11);
      bus_rd(0, 0, 3'd0, rv, oe);
      check("R9 read prefers A", rv, 8'h11);

      // R3 commit on release
      pa = pulses_a;
      @(negedge clk);
      addr = 3'd3; data_in = 8'h44; cs_a_n = 1'b0;
      wait_cyc(1);
      wr_n = 1'b0;
      wait_cyc(8);
      cs_a_n = 1'b1; wr_n = 1'b1;
      wait_cyc(1);
      cs_a_n = 1'b1;
      wait_cyc(4);
      bus_rd(0, 1, 3'd3, rv, oe);
      check("R3 no commit without select at release", rv, 8'h9F);
      @(negedge clk);
      addr = 3'd6; data_in = 8'h66; cs_a_n = 1'b0;
      wait_cyc(1);
      wr_n = 1'b0;
      wait_cyc(8);
      check("R3 held strobe no pulse", pulses_a - pa, 0);
      wr_n = 1'b1;
      wait_cyc(5);
      cs_a_n = 1'b1;
      check("R3 pulse after release", pulses_a - pa, 1);
      wait_cyc(3);
      bus_wr(1, 1, 3'd3, 8'h00);
      bus_rd(0, 1, 3'd3, rv, oe);
      check("R3 unselected write ignored", rv, 8'h9F);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule